// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm and Update Cycle

This block keeps a time of day as three bytes (seconds, minutes, hours) and advances them once per second. The second is counted in ticks of a slow timebase strobe (`tb_tick`, nominally 32768 ticks per second) sampled on the fast system clock. Each advance is one update cycle. It sets a sticky update-ended flag. In the same cycle the block compares the three alarm bytes with the freshly advanced time and sets an alarm flag on a match. A status output `uip` warns software that an update is close, so a multi-byte read of the time can be deferred.

Time bytes are packed BCD (tens in bits 7:4, units in bits 3:0) or plain binary, selected by `bin_mode`. Hours run 0..23, or in 12-hour form as 1..12 with bit 7 marking PM. Software stops the clock for writing in two ways. A freeze (`set_mode`) keeps the sub-second phase running. A divider reset (`div_ctl == 2'b11`) parks the phase. While frozen, the time bytes are written through a load port.

A small state machine in `rtc_phase_ctl` governs the phase. It has three states:
- **HOLD**: divider reset. The phase is parked at half a second.
- **RUN**: counting.
- **FROZEN**: set mode. The phase keeps counting but nothing advances.

Its transitions are:
- **HOLD→RUN** and **HOLD→FROZEN** on release of the divider reset, according to `set_mode`.
- **RUN→FROZEN** when `set_mode` rises.
- **FROZEN→RUN** when `set_mode` falls.
- **RUN→HOLD** and **FROZEN→HOLD** whenever the divider reset is applied.

Reset enters HOLD.

Top module: `rtc_tod_alarm`

## Requirements
- R1: After reset the three time bytes read 0x00, both flags and `irq` are low, and `uip` is low.
- R2: In RUN, an update happens once every TICKS_PER_SEC timebase ticks. The update sets `upd_flag` and advances the seconds by one.
- R3: Seconds and minutes wrap from 59 to 0 and carry to the next field. In 24-hour mode hours wrap from 23 to 0. This holds in both BCD (`bin_mode`=0, tens in bits 7:4) and binary (`bin_mode`=1).
- R4: With `hr24_mode`=0 the hour byte holds 1..12 in bits 6:0 and PM in bit 7. 11 AM advances to 12 PM, 11 PM advances to 12 AM, and 12 advances to 1 in the same half-day.
- R5: An alarm byte whose bits 7:6 are both 1 is a wildcard. On an update, `alm_flag` is set when every non-wildcard alarm byte equals the corresponding newly advanced time byte.
- R6: `uip` is high during the last UIP_WINDOW timebase ticks before each update and low from the update onward.
- R7: While `div_ctl` is 2'b11 the time does not advance, no flag is set and `uip` stays low. After release, the first update comes TICKS_PER_SEC/2 ticks later.
- R8: While `set_mode` is 1 the time holds, no update happens and `uip` is low. A `ld_en` strobe writes the three time bytes. After `set_mode` clears, updates keep the sub-second phase they had before the freeze.
- R9: Both flags stay set until a `flag_clr` strobe. An update in the same cycle as the strobe wins.
- R10: `irq` is high when `upd_flag` and `upd_ie` are high and `set_mode` is low, or when `alm_flag` and `alm_ie` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | One-cycle timebase strobe |
| div_ctl | input | 2 | Divider control; 2'b11 holds the divider in reset |
| set_mode | input | 1 | Freeze the time for writing |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| upd_ie | input | 1 | Update interrupt enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| ld_en | input | 1 | Write the load bytes into the time |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| alm_sec | input | 8 | Alarm seconds (wildcard when bits 7:6 = 11) |
| alm_min | input | 8 | Alarm minutes (wildcard when bits 7:6 = 11) |
| alm_hour | input | 8 | Alarm hours (wildcard when bits 7:6 = 11) |
| flag_clr | input | 1 | Clear both flags |
| tod_sec | output | 8 | Current seconds |
| tod_min | output | 8 | Current minutes |
| tod_hour | output | 8 | Current hours |
| upd_flag | output | 1 | Update-ended flag |
| alm_flag | output | 1 | Alarm flag |
| uip | output | 1 | Update in progress |
| irq | output | 1 | Interrupt request |

## Verification
The phase counter sits in front of every output, so a wrong phase or state is visible within one second. A phase error moves the `upd_flag` rise away from its expected cycle after a release or a freeze. It also changes the number of cycles `uip` stays high before that rise. A stuck FROZEN or HOLD state shows up as a missing update, or as an update the scoreboard did not ask for. A wrong carry or encoding appears in the time bytes in the very cycle the flag rises, where the monitor compares all three bytes, the alarm flag and `irq`.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

    typedef enum logic [1:0] {
        PH_HOLD   = 2'd0,
        PH_RUN    = 2'd1,
        PH_FROZEN = 2'd2
    } ph_state_t;

    localparam logic [1:0] WILDCARD_TAG = 2'b11;

    // byte (BCD or binary) to integer value
    function automatic logic [6:0] tod_dec(input logic [7:0] v, input logic bin);
        logic [6:0] tens;
        tens = {3'b000, v[7:4]};
        return bin ? v[6:0] : (tens * 7'd10 + {3'b000, v[3:0]});
    endfunction

    // integer value to byte (BCD or binary)
    function automatic logic [7:0] tod_enc(input logic [6:0] n, input logic bin);
        logic [6:0] t;
        logic [6:0] o;
        t = n / 7'd10;
        o = n - t * 7'd10;
        return bin ? {1'b0, n} : {t[3:0], o[3:0]};
    endfunction

endpackage

// File: rtl/rtc_phase_ctl.sv
module rtc_phase_ctl
    import rtc_tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_WINDOW    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_tick,
    input  logic div_rst,
    input  logic set_mode,
    output logic upd_pulse,
    output logic uip
);
    localparam int PH_W = $clog2(TICKS_PER_SEC);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(TICKS_PER_SEC - 1);
    localparam logic [PH_W-1:0] PH_HALF  = PH_W'(TICKS_PER_SEC / 2);
    localparam logic [PH_W-1:0] PH_WARN  = PH_W'(TICKS_PER_SEC - UIP_WINDOW);

    ph_state_t state, state_nx;
    logic [PH_W-1:0] phase;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_HOLD;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_HOLD:   if (!div_rst) state_nx = set_mode ? PH_FROZEN : PH_RUN;
            PH_RUN:    if (div_rst) state_nx = PH_HOLD;
                       else if (set_mode) state_nx = PH_FROZEN;
            PH_FROZEN: if (div_rst) state_nx = PH_HOLD;
                       else if (!set_mode) state_nx = PH_RUN;
            default:   state_nx = PH_HOLD;
        endcase
    end

    // sub-second phase: parked at half a second in HOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phase <= '0;
        else if (state == PH_HOLD) phase <= PH_HALF;
        else if (tb_tick)          phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    // outputs
    always_comb begin
        upd_pulse = 1'b0;
        uip       = 1'b0;
        unique case (state)
            PH_RUN: begin
                upd_pulse = tb_tick && (phase == PH_LAST);
                uip       = (phase >= PH_WARN);
            end
            PH_HOLD, PH_FROZEN: begin
                upd_pulse = 1'b0;
                uip       = 1'b0;
            end
            default: ;
        endcase
    end

    assert_uip_before_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> uip) else $error("update without uip warning");

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rst && $past(div_rst)) |-> (!upd_pulse && !uip))
        else $error("activity during divider reset");

    assert_release_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_HOLD && state != PH_HOLD) |-> (phase == PH_HALF))
        else $error("phase not at half second on release");

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic       ld_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic [7:0] sec_nx,
    output logic [7:0] min_nx,
    output logic [7:0] hour_nx
);
    logic [6:0] s_v, m_v, h_raw, h24, h24n, h12n;
    logic       s_wrap, m_wrap, pm;

    always_comb begin
        s_v    = tod_dec(sec_q, bin_mode);
        m_v    = tod_dec(min_q, bin_mode);
        h_raw  = tod_dec({1'b0, hour_q[6:0]}, bin_mode);
        pm     = !hr24_mode && hour_q[7];
        s_wrap = (s_v >= 7'd59);
        m_wrap = (m_v >= 7'd59);

        if (hr24_mode) h24 = h_raw;
        else           h24 = ((h_raw == 7'd12) ? 7'd0 : h_raw) + (pm ? 7'd12 : 7'd0);
        h24n = (h24 >= 7'd23) ? 7'd0 : h24 + 7'd1;
        h12n = (h24n >= 7'd12) ? h24n - 7'd12 : h24n;
        if (h12n == 7'd0) h12n = 7'd12;

        sec_nx = tod_enc(s_wrap ? 7'd0 : s_v + 7'd1, bin_mode);
        min_nx = s_wrap ? tod_enc(m_wrap ? 7'd0 : m_v + 7'd1, bin_mode) : min_q;
        if (!(s_wrap && m_wrap))  hour_nx = hour_q;
        else if (hr24_mode)       hour_nx = tod_enc(h24n, bin_mode);
        else                      hour_nx = {h24n >= 7'd12, tod_enc(h12n, bin_mode)[6:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h00;
        end else if (ld_en) begin
            sec_q  <= ld_sec;
            min_q  <= ld_min;
            hour_q <= ld_hour;
        end else if (adv) begin
            sec_q  <= sec_nx;
            min_q  <= min_nx;
            hour_q <= hour_nx;
        end
    end

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_en && tod_dec(sec_q, bin_mode) == 7'd59) |=> (sec_q == 8'h00))
        else $error("seconds did not wrap");

    assert_time_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)))
        else $error("time moved without an update");

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_tod_pkg::*;
#(
    parameter int FIELDS = 3
) (
    input  logic [FIELDS-1:0][7:0] alm_b,
    input  logic [FIELDS-1:0][7:0] tod_b,
    output logic                   hit
);
    logic [FIELDS-1:0] fld_ok;

    for (genvar i = 0; i < FIELDS; i++) begin : g_fld
        assign fld_ok[i] = (alm_b[i][7:6] == WILDCARD_TAG) || (alm_b[i] == tod_b[i]);
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/rtc_tod_alarm.sv
module rtc_tod_alarm
    import rtc_tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_WINDOW    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_tick,
    input  logic [1:0] div_ctl,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic       upd_ie,
    input  logic       alm_ie,
    input  logic       ld_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       flag_clr,
    output logic [7:0] tod_sec,
    output logic [7:0] tod_min,
    output logic [7:0] tod_hour,
    output logic       upd_flag,
    output logic       alm_flag,
    output logic       uip,
    output logic       irq
);
    logic       div_rst, upd_pulse, hit;
    logic [7:0] sec_nx, min_nx, hour_nx;

    assign div_rst = (div_ctl == 2'b11);

    rtc_phase_ctl #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_WINDOW   (UIP_WINDOW)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_tick  (tb_tick),
        .div_rst  (div_rst),
        .set_mode (set_mode),
        .upd_pulse(upd_pulse),
        .uip      (uip)
    );

    rtc_time_regs u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (upd_pulse),
        .bin_mode (bin_mode),
        .hr24_mode(hr24_mode),
        .ld_en    (ld_en),
        .ld_sec   (ld_sec),
        .ld_min   (ld_min),
        .ld_hour  (ld_hour),
        .sec_q    (tod_sec),
        .min_q    (tod_min),
        .hour_q   (tod_hour),
        .sec_nx   (sec_nx),
        .min_nx   (min_nx),
        .hour_nx  (hour_nx)
    );

    rtc_alarm_match #(.FIELDS(3)) u_match (
        .alm_b({alm_hour, alm_min, alm_sec}),
        .tod_b({hour_nx, min_nx, sec_nx}),
        .hit  (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_flag <= 1'b0;
            alm_flag <= 1'b0;
        end else begin
            upd_flag <= upd_pulse | (upd_flag & ~flag_clr);
            alm_flag <= (upd_pulse & hit) | (alm_flag & ~flag_clr);
        end
    end

    assign irq = (upd_flag & upd_ie & ~set_mode) | (alm_flag & alm_ie);

    assert_alarm_with_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> upd_flag) else $error("alarm flag without update");

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !upd_pulse) |=> !upd_flag) else $error("flag not cleared");

    assert_frozen_no_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && $past(set_mode)) |-> !upd_pulse) else $error("update while frozen");

endmodule

// File: tb/rtc_tod_alarm_bench.sv
module rtc_tod_alarm_bench;
    localparam int TPS = 64;
    localparam int WIN = 8;

    typedef struct packed {
        logic [7:0] s;
        logic [7:0] m;
        logic [7:0] h;
        logic       alm;
        logic       irq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_tick = 1'b1;
    logic [1:0] div_ctl = 2'b01;
    logic set_mode = 1'b1, bin_mode = 1'b0, hr24_mode = 1'b1;
    logic upd_ie = 1'b0, alm_ie = 1'b0, ld_en = 1'b0;
    logic [7:0] ld_sec = 8'h00, ld_min = 8'h00, ld_hour = 8'h00;
    logic [7:0] alm_sec = 8'hC0, alm_min = 8'hC0, alm_hour = 8'hC0;
    logic mon_clr = 1'b0, main_clr = 1'b0, hold_flags = 1'b0, prev_flag = 1'b0;
    logic flag_clr;
    logic [7:0] tod_sec, tod_min, tod_hour;
    logic upd_flag, alm_flag, uip, irq;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    assign flag_clr = mon_clr | main_clr;

    always #10 clk = ~clk;

    rtc_tod_alarm #(.TICKS_PER_SEC(TPS), .UIP_WINDOW(WIN)) u_rtc_tod_alarm (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .div_ctl(div_ctl),
        .set_mode(set_mode), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
        .upd_ie(upd_ie), .alm_ie(alm_ie), .ld_en(ld_en), .ld_sec(ld_sec),
        .ld_min(ld_min), .ld_hour(ld_hour), .alm_sec(alm_sec), .alm_min(alm_min),
        .alm_hour(alm_hour), .flag_clr(flag_clr), .tod_sec(tod_sec),
        .tod_min(tod_min), .tod_hour(tod_hour), .upd_flag(upd_flag),
        .alm_flag(alm_flag), .uip(uip), .irq(irq)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] s, m, h, input logic a, i);
        exp_t e;
        e.s = s; e.m = m; e.h = h; e.alm = a; e.irq = i;
        q.push_back(e);
    endtask

    // monitor: pops one expected item on every rise of the update flag
    always @(negedge clk) begin
        mon_clr <= 1'b0;
        prev_flag <= upd_flag;
        if (rst_n && upd_flag && !prev_flag) begin
            if (q.size() == 0) begin
                check_eq("R7/R8", "unexpected update", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check_eq("R2/R3/R4", "seconds", {24'd0, tod_sec}, {24'd0, e.s});
                check_eq("R3/R4", "minutes", {24'd0, tod_min}, {24'd0, e.m});
                check_eq("R3/R4", "hours", {24'd0, tod_hour}, {24'd0, e.h});
                check_eq("R5", "alarm flag", {31'd0, alm_flag}, {31'd0, e.alm});
                check_eq("R10", "irq", {31'd0, irq}, {31'd0, e.irq});
            end
            if (!hold_flags) mon_clr <= 1'b1;
        end
    end

    task automatic wait_flag();
        do @(negedge clk); while (!upd_flag);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic scenario(input logic bm, h24, input logic [7:0] lh, lm, ls,
                            input logic [7:0] ah, am, as_);
        bin_mode = bm; hr24_mode = h24;
        alm_hour = ah; alm_min = am; alm_sec = as_;
        ld_hour = lh; ld_min = lm; ld_sec = ls; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
        set_mode = 1'b0;
        drain();
        set_mode = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        int ucnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "sec", {24'd0, tod_sec}, 32'h0);
        check_eq("R1", "min", {24'd0, tod_min}, 32'h0);
        check_eq("R1", "hour", {24'd0, tod_hour}, 32'h0);
        check_eq("R1", "flags", {30'd0, upd_flag, alm_flag}, 32'h0);
        check_eq("R1", "irq/uip", {30'd0, irq, uip}, 32'h0);

        // timing block: BCD 24h from 01:02:03, all alarm bytes wildcard
        ld_hour = 8'h01; ld_min = 8'h02; ld_sec = 8'h03; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
        push(8'h04, 8'h02, 8'h01, 1'b1, 1'b0);
        push(8'h05, 8'h02, 8'h01, 1'b1, 1'b0);
        push(8'h06, 8'h02, 8'h01, 1'b1, 1'b0);
        push(8'h07, 8'h02, 8'h01, 1'b1, 1'b0);
        push(8'h08, 8'h02, 8'h01, 1'b0, 1'b1);
        set_mode = 1'b0;
        wait_flag();
        // R2 period and R6 warning window
        cnt = 0; ucnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (uip) ucnt++;
        end while (!upd_flag);
        check_eq("R2", "cycles between updates", cnt, TPS);
        check_eq("R6", "uip high cycles", ucnt, WIN);
        check_eq("R6", "uip at update", {31'd0, uip}, 32'd0);

        // R8: freeze keeps the sub-second phase
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) set_mode = 1'b1;
            if (cnt == 60) begin
                check_eq("R8", "uip while frozen", {31'd0, uip}, 32'd0);
                check_eq("R8", "sec while frozen", {24'd0, tod_sec}, 32'h05);
            end
            if (cnt == 100) set_mode = 1'b0;
        end while (!upd_flag);
        check_eq("R8", "update after freeze", cnt, 2 * TPS);

        // R7: divider reset then release
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) div_ctl = 2'b11;
            if (cnt == 150) begin
                check_eq("R7", "uip in divider reset", {31'd0, uip}, 32'd0);
                check_eq("R7", "sec in divider reset", {24'd0, tod_sec}, 32'h06);
            end
            if (cnt == 200) div_ctl = 2'b10;
        end while (!upd_flag);
        check_eq("R7", "first update after release", cnt, 200 + TPS / 2 + 1);

        // R9/R10: non-matching alarm, update interrupt enabled, flags held
        @(negedge clk);
        alm_sec = 8'h30; upd_ie = 1'b1; hold_flags = 1'b1;
        wait_flag();
        @(negedge clk);
        check_eq("R9", "flag sticky", {31'd0, upd_flag}, 32'd1);
        check_eq("R10", "irq with upd_ie", {31'd0, irq}, 32'd1);
        set_mode = 1'b1;
        @(negedge clk);
        check_eq("R10", "irq masked in set mode", {31'd0, irq}, 32'd0);
        main_clr = 1'b1;
        @(negedge clk);
        main_clr = 1'b0;
        check_eq("R9", "flag cleared", {31'd0, upd_flag}, 32'd0);
        hold_flags = 1'b0; upd_ie = 1'b0; alm_ie = 1'b1;
        @(negedge clk);

        // R3 BCD 24h day wrap
        push(8'h59, 8'h59, 8'h23, 1'b1, 1'b1);
        push(8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
        scenario(1'b0, 1'b1, 8'h23, 8'h59, 8'h58, 8'hC0, 8'hC0, 8'hC0);
        // R3 BCD decade carry, R5 partial wildcard
        push(8'h00, 8'h00, 8'h10, 1'b1, 1'b1);
        push(8'h01, 8'h00, 8'h10, 1'b1, 1'b1);
        scenario(1'b0, 1'b1, 8'h09, 8'h59, 8'h59, 8'h10, 8'h00, 8'hC0);
        // R4 binary 12h: 11 PM -> 12 AM, R5 exact alarm then miss
        push(8'h00, 8'h00, 8'h0C, 1'b1, 1'b1);
        push(8'h01, 8'h00, 8'h0C, 1'b0, 1'b0);
        scenario(1'b1, 1'b0, 8'h8B, 8'h3B, 8'h3B, 8'h0C, 8'h00, 8'h00);
        // R4 BCD 12h: 11 AM -> 12 PM
        push(8'h00, 8'h00, 8'h92, 1'b1, 1'b1);
        scenario(1'b0, 1'b0, 8'h11, 8'h59, 8'h59, 8'hC0, 8'h00, 8'h00);
        // R4 BCD 12h: 12 AM -> 1 AM, alarm at 1 PM misses
        push(8'h00, 8'h00, 8'h01, 1'b0, 1'b0);
        scenario(1'b0, 1'b0, 8'h12, 8'h59, 8'h59, 8'h81, 8'hC0, 8'hC0);
        // R3 binary 24h day wrap
        push(8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
        scenario(1'b1, 1'b1, 8'h17, 8'h3B, 8'h3B, 8'hC0, 8'hC0, 8'hC0);

        check_eq("R2", "queue drained", q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule